// File: doc/BRIEF.md
# Page Write Timer with Toggle Polling

This block sits behind the address/data demultiplexer of a non-volatile memory interface and turns a burst of single-byte write requests into one page commit. The first accepted write opens a page: it fixes the page tag, taken from the upper address bits, and stores its byte in a page buffer. Every byte has its own valid flag. Further writes with the same tag fill or overwrite bytes in the buffer. Each accepted write restarts a byte-load window that is counted in microsecond ticks. When the window runs out with no new byte, the page closes. The block then issues a one-cycle commit carrying the tag, the buffered bytes and the valid mask to the array model.

A fixed programming time follows, also counted in ticks. During it the block reports busy, ignores all writes, and supplies a read-data override. The poll bit in that override inverts on every read, so software can detect the end of the write early. When programming ends the buffer is emptied and the block accepts a new page. Both durations are parameters so that a bench can shorten them.

Top module: `page_write_timer`

## Requirements
- R1: After reset, busy, commitValid and rdOvrEn are low and no page is open.
- R2: A write request while idle opens a page. Address bits 14..7 become the page tag, reported later on commitTag. Bits 6..0 select the byte offset inside the page.
- R3: Each accepted write restarts the load window. The page closes on the clock edge that samples the WIN_US-th usTick since the last accepted write. commitValid is high for exactly the one cycle after that edge.
- R4: At commit, byte k of commitData (bits 8k+7..8k) holds the last value written to offset k, and commitMask bit k is set exactly for the offsets written. A page can hold from 1 to 128 bytes.
- R5: During loading, a write whose tag differs from the open page's tag is ignored. It changes no buffered byte or mask bit and does not restart the window.
- R6: Writes that arrive while busy is high are ignored. They appear in neither the current commit nor the next page.
- R7: busy rises on the commit edge and falls on the edge that samples the PROG_US-th usTick after it. The buffer is then empty, and a later page starts with only its own bytes.
- R8: rdOvrEn equals busy. Each read request while busy inverts rdOvrBit, visible in the following cycle. The first read of each programming cycle returns 1. The array model places this bit at data bit 6.
- R9: Read requests outside programming have no effect on the poll sequence: the first read of the next programming cycle still returns 1.
- R10: When usTick and an accepted write occur in the same cycle, the write wins: the window restarts and that tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| usTick | input | 1 | One-cycle pulse each microsecond |
| wrReq | input | 1 | Forwarded byte write request |
| wrAddr | input | ADDR_W (15) | Write address: tag in upper bits, offset in lower OFS_W bits |
| wrData | input | DATA_W (8) | Write data byte |
| rdReq | input | 1 | Forwarded read request |
| commitValid | output | 1 | One-cycle page commit strobe |
| commitTag | output | ADDR_W-OFS_W (8) | Page tag of the commit |
| commitData | output | 2^OFS_W*DATA_W (1024) | Buffered page bytes, byte k at bits 8k+7..8k |
| commitMask | output | 2^OFS_W (128) | Valid flag per byte |
| busy | output | 1 | Programming cycle in progress |
| rdOvrEn | output | 1 | Read data override active |
| rdOvrBit | output | 1 | Toggling poll bit for read data bit 6 |

## Verification
The assertions assume that usTick, wrReq and rdReq are clean single-cycle, synchronous levels, and that usTick arrives no more often than once per clock. They also assume that commit content is sampled only while commitValid or busy is high. Stimulus is driven after the clock edge and sampled one time unit later. The random phase mixes ticks, matching writes, writes with a foreign tag, and reads with independent probabilities. This includes ticks that coincide with writes. The shortened window and programming lengths make every page reach both its commit and its end of programming many times over.

// File: rtl/pwt_pkg.sv
package pwt_pkg;

  typedef enum logic [1:0] {
    PW_IDLE = 2'd0,
    PW_LOAD = 2'd1,
    PW_PROG = 2'd2
  } pwStateE;

  // strobes from control to datapath
  typedef struct packed {
    logic openPage;  // latch the tag of the incoming write
    logic loadByte;  // store the incoming byte and set its valid flag
    logic clearAll;  // drop all valid flags (end of programming)
  } pwStrbT;

endpackage

// File: rtl/pwt_datapath.sv
module pwt_datapath
  import pwt_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter int OFS_W  = 7
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  pwStrbT                          strb,
  input  logic [ADDR_W-1:0]               wrAddr,
  input  logic [DATA_W-1:0]               wrData,
  output logic                            tagHit,
  output logic [ADDR_W-OFS_W-1:0]         pageTag,
  output logic [(1<<OFS_W)*DATA_W-1:0]    pageData,
  output logic [(1<<OFS_W)-1:0]           pageMask
);

  localparam int PAGE_BYTES = 1 << OFS_W;
  localparam int TAG_W      = ADDR_W - OFS_W;

  logic [TAG_W-1:0] tagQ;
  logic [TAG_W-1:0] wrTag;
  logic [OFS_W-1:0] wrOfs;

  assign wrTag = wrAddr[ADDR_W-1:OFS_W];
  assign wrOfs = wrAddr[OFS_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN)              tagQ <= '0;
    else if (strb.openPage) tagQ <= wrTag;
  end

  assign tagHit  = (wrTag == tagQ);
  assign pageTag = tagQ;

  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_byte
    logic [DATA_W-1:0] byteQ;
    logic              validQ;
    logic              hitThis;

    assign hitThis = strb.loadByte && (wrOfs == OFS_W'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        byteQ  <= '0;
        validQ <= 1'b0;
      end else if (strb.clearAll) begin
        validQ <= 1'b0;
      end else if (hitThis) begin
        byteQ  <= wrData;
        validQ <= 1'b1;
      end
    end

    assign pageData[i*DATA_W +: DATA_W] = byteQ;
    assign pageMask[i]                  = validQ;
  end

endmodule

// File: rtl/pwt_ctrl.sv
module pwt_ctrl
  import pwt_pkg::*;
#(
  parameter int WIN_US  = 100,
  parameter int PROG_US = 5000
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   usTick,
  input  logic   wrReq,
  input  logic   rdReq,
  input  logic   tagHit,
  output pwStrbT strb,
  output logic   busy,
  output logic   commitValid,
  output logic   pollBit
);

  localparam int WIN_W  = $clog2(WIN_US + 1);
  localparam int PROG_W = $clog2(PROG_US + 1);

  pwStateE           stateQ;
  logic [WIN_W-1:0]  winCnt;
  logic [PROG_W-1:0] progCnt;
  logic              tglQ;
  logic              accept;
  logic              winLast;
  logic              progLast;

  assign accept   = wrReq && ((stateQ == PW_IDLE) || ((stateQ == PW_LOAD) && tagHit));
  assign winLast  = (stateQ == PW_LOAD) && !accept && usTick && (winCnt == WIN_W'(WIN_US - 1));
  assign progLast = (stateQ == PW_PROG) && usTick && (progCnt == PROG_W'(PROG_US - 1));

  always_comb begin
    strb          = '0;
    strb.openPage = wrReq && (stateQ == PW_IDLE);
    strb.loadByte = accept;
    strb.clearAll = progLast;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ      <= PW_IDLE;
      winCnt      <= '0;
      progCnt     <= '0;
      tglQ        <= 1'b0;
      commitValid <= 1'b0;
    end else begin
      commitValid <= winLast;
      case (stateQ)
        PW_IDLE: begin
          if (accept) begin
            stateQ <= PW_LOAD;
            winCnt <= '0;
          end
        end
        PW_LOAD: begin
          if (accept) begin
            winCnt <= '0;
          end else if (winLast) begin
            stateQ  <= PW_PROG;
            winCnt  <= '0;
            progCnt <= '0;
            tglQ    <= 1'b0;
          end else if (usTick) begin
            winCnt <= winCnt + 1'b1;
          end
        end
        PW_PROG: begin
          if (rdReq) tglQ <= ~tglQ;
          if (progLast) begin
            stateQ  <= PW_IDLE;
            progCnt <= '0;
          end else if (usTick) begin
            progCnt <= progCnt + 1'b1;
          end
        end
        default: stateQ <= PW_IDLE;
      endcase
    end
  end

  assign busy    = (stateQ == PW_PROG);
  assign pollBit = tglQ;

  // R3: the commit strobe never lasts longer than one cycle
  p_commit_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    commitValid |=> !commitValid);

  // R3: programming starts together with the commit strobe
  p_busy_start_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> commitValid);

  // R3: the window count stays below its limit while loading
  p_win_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == PW_LOAD) |-> (winCnt < WIN_W'(WIN_US)));

  // R7: the programming count stays below its limit
  p_prog_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (progCnt < PROG_W'(PROG_US)));

  // R8: every read during programming flips the poll bit
  p_poll_flip_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && rdReq) |=> (pollBit != $past(pollBit)));

endmodule

// File: rtl/page_write_timer.sv
module page_write_timer
  import pwt_pkg::*;
#(
  parameter int ADDR_W  = 15,
  parameter int DATA_W  = 8,
  parameter int OFS_W   = 7,
  parameter int WIN_US  = 100,
  parameter int PROG_US = 5000
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         usTick,
  input  logic                         wrReq,
  input  logic [ADDR_W-1:0]            wrAddr,
  input  logic [DATA_W-1:0]            wrData,
  input  logic                         rdReq,
  output logic                         commitValid,
  output logic [ADDR_W-OFS_W-1:0]      commitTag,
  output logic [(1<<OFS_W)*DATA_W-1:0] commitData,
  output logic [(1<<OFS_W)-1:0]        commitMask,
  output logic                         busy,
  output logic                         rdOvrEn,
  output logic                         rdOvrBit
);

  pwStrbT strb;
  logic   tagHit;
  logic   pollBit;

  pwt_ctrl #(
    .WIN_US (WIN_US),
    .PROG_US(PROG_US)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .usTick     (usTick),
    .wrReq      (wrReq),
    .rdReq      (rdReq),
    .tagHit     (tagHit),
    .strb       (strb),
    .busy       (busy),
    .commitValid(commitValid),
    .pollBit    (pollBit)
  );

  pwt_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .OFS_W (OFS_W)
  ) u_data (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .tagHit  (tagHit),
    .pageTag (commitTag),
    .pageData(commitData),
    .pageMask(commitMask)
  );

  assign rdOvrEn  = busy;
  assign rdOvrBit = pollBit;

  // R4: a commit always carries at least one valid byte
  p_commit_nonempty_r4: assert property (@(posedge clk) disable iff (!rstN)
    commitValid |-> (commitMask != '0));

  // R6: while programming, the committed page content cannot change
  p_hold_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($stable(commitMask) && $stable(commitTag) && $stable(commitData)));

endmodule

// File: tb/page_write_timer_bench.sv
module page_write_timer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WIN        = 4;
  localparam int PROG       = 10;
  localparam int NB         = 128;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          usTick = 1'b0;
  logic          wrReq = 1'b0;
  logic [14:0]   wrAddr = '0;
  logic [7:0]    wrData = '0;
  logic          rdReq = 1'b0;
  logic          commitValid;
  logic [7:0]    commitTag;
  logic [NB*8-1:0] commitData;
  logic [NB-1:0] commitMask;
  logic          busy;
  logic          rdOvrEn;
  logic          rdOvrBit;

  int compared = 0;
  int mismatched = 0;

  // reference model state
  int         mMode = 0;    // 0 idle, 1 load, 2 programming
  int         mWin  = 0;
  int         mProg = 0;
  bit         mTgl  = 0;
  bit         mCommit = 0;
  logic [7:0] mTag = '0;
  bit [NB-1:0] mMask = '0;
  logic [7:0] mData [NB];

  always #(CLK_PERIOD/2) clk = ~clk;

  page_write_timer #(
    .WIN_US (WIN),
    .PROG_US(PROG)
  ) u_page_write_timer (
    .clk(clk), .rstN(rstN), .usTick(usTick), .wrReq(wrReq), .wrAddr(wrAddr),
    .wrData(wrData), .rdReq(rdReq), .commitValid(commitValid), .commitTag(commitTag),
    .commitData(commitData), .commitMask(commitMask), .busy(busy),
    .rdOvrEn(rdOvrEn), .rdOvrBit(rdOvrBit)
  );

  task automatic chk(input bit ok, input string req, input logic [NB-1:0] act, input logic [NB-1:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit expBusy();
    return mMode == 2;
  endfunction

  // model update for one clock edge, from the requirements
  task automatic modelEdge(input bit tk, input bit wr, input bit rd, input logic [14:0] a, input logic [7:0] d);
    mCommit = 0;
    case (mMode)
      0: if (wr) begin                               // R2
        mMode = 1; mTag = a[14:7]; mMask[a[6:0]] = 1'b1; mData[a[6:0]] = d; mWin = 0;
      end
      1: begin
        if (wr && a[14:7] == mTag) begin             // R10: write wins over tick
          mMask[a[6:0]] = 1'b1; mData[a[6:0]] = d; mWin = 0;
        end else if (tk) begin                       // R5: foreign tag ignored
          if (mWin == WIN-1) begin
            mMode = 2; mCommit = 1; mProg = 0; mTgl = 0;
          end else mWin++;
        end
      end
      default: begin                                 // R6: writes ignored
        if (rd) mTgl = ~mTgl;
        if (tk) begin
          if (mProg == PROG-1) begin mMode = 0; mMask = '0; end
          else mProg++;
        end
      end
    endcase
  endtask

  task automatic compareOut();
    chk(busy == expBusy(), "R7 busy", NB'(busy), NB'(expBusy()));
    chk(commitValid == mCommit, "R3 commitValid", NB'(commitValid), NB'(mCommit));
    chk(rdOvrEn == expBusy(), "R8 rdOvrEn", NB'(rdOvrEn), NB'(expBusy()));
    if (expBusy()) chk(rdOvrBit == mTgl, "R8 rdOvrBit", NB'(rdOvrBit), NB'(mTgl));
    if (mCommit) begin
      chk(commitTag == mTag, "R2 commitTag", NB'(commitTag), NB'(mTag));
      chk(commitMask == mMask, "R4 commitMask", commitMask, mMask);
      for (int k = 0; k < NB; k++)
        if (mMask[k]) chk(commitData[k*8 +: 8] == mData[k], "R4 commitData",
                          NB'(commitData[k*8 +: 8]), NB'(mData[k]));
    end
  endtask

  task automatic step(input bit tk, input bit wr, input bit rd, input logic [14:0] a, input logic [7:0] d);
    usTick = tk; wrReq = wr; rdReq = rd; wrAddr = a; wrData = d;
    @(posedge clk); #1;
    modelEdge(tk, wr, rd, a, d);
    compareOut();
    usTick = 0; wrReq = 0; rdReq = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1, 0, 0, '0, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int k = 0; k < NB; k++) mData[k] = '0;
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    #1;
    // R1: reset state
    chk(busy == 0 && commitValid == 0 && rdOvrEn == 0, "R1 reset outputs",
        NB'({busy, commitValid, rdOvrEn}), '0);

    // R9: reads while idle must not disturb the poll sequence
    step(0, 0, 1, '0, '0);
    step(0, 0, 1, '0, '0);
    chk(rdOvrEn == 0, "R9 idle read", NB'(rdOvrEn), '0);

    // R4: full page of 128 bytes, then window expiry (R3)
    for (int k = 0; k < NB; k++) step(0, 1, 0, {8'h05, 7'(k)}, 8'(k * 3 + 1));
    step(0, 1, 0, {8'h05, 7'd9}, 8'hEE);             // R4 overwrite
    ticks(WIN);
    // R8/R9: first poll read returns 1, then alternates
    step(0, 0, 1, '0, '0);
    chk(rdOvrBit == 1'b1, "R8 R9 first poll", NB'(rdOvrBit), NB'(1));
    step(0, 0, 1, '0, '0);
    // R6: writes during programming are dropped
    step(0, 1, 0, {8'h05, 7'd3}, 8'h77);
    step(1, 1, 1, {8'h06, 7'd4}, 8'h66);
    ticks(PROG);
    chk(busy == 0, "R7 end of programming", NB'(busy), '0);

    // R5: foreign tag write ignored, does not restart window
    step(0, 1, 0, {8'h03, 7'd1}, 8'hA1);
    ticks(WIN - 1);
    step(0, 1, 0, {8'h04, 7'd2}, 8'hB2);
    step(1, 0, 0, '0, '0);
    chk(commitValid == 1, "R5 no restart", NB'(commitValid), NB'(1));
    ticks(PROG);

    // R10: tick together with accepted write restarts window
    step(0, 1, 0, {8'h07, 7'd0}, 8'h11);
    ticks(WIN - 1);
    step(1, 1, 0, {8'h07, 7'd127}, 8'h22);
    ticks(WIN - 1);
    chk(commitValid == 0 && busy == 0, "R10 window restarted", NB'(busy), '0);
    step(1, 0, 0, '0, '0);
    ticks(PROG);

    // random phase
    for (int n = 0; n < 15000; n++) begin
      bit tk, wr, rd;
      logic [7:0] tg;
      tk = ($urandom % 10) < 3;
      wr = ($urandom % 10) < 3;
      rd = ($urandom % 10) < 2;
      if (mMode == 1 && ($urandom % 5) != 0) tg = mTag;
      else tg = 8'($urandom % 4);
      step(tk, wr, rd, {tg, 7'($urandom)}, 8'($urandom));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule